// File: doc/BRIEF.md
# CPM Branch Metric Filter Bank

This block produces the branch metrics that a Viterbi detector for continuous phase modulation needs once per symbol. Signed in-phase and quadrature samples arrive two per symbol. Each symbol's sample pair is correlated against a fixed bank of complex reference coefficients, with one coefficient set for each candidate branch. The result is the real part of the complex correlation.

The multiplies are bit-serial. One bit of every stored sample is consumed per clock, least significant bit first. All branches are served in parallel from the same bit slice. Accumulation keeps full precision. Each finished correlation then loses its two top bits and is rounded down to a narrow metric word. All eight metrics update together and are announced by a one-clock strobe. The upstream logic must not offer the next symbol's samples until that strobe has been seen.

Top module: `cpm_bm_bank`

## Requirements
- R1: While `rst_n` is low and after its release, `metric_valid` is 0 and every metric reads 0 until the first symbol completes.
- R2: Accepted samples alternate roles. The first sample accepted after reset or after a finished symbol is sample 0 of the symbol. The next accepted sample is sample 1, and it starts the computation.
- R3: The full-precision correlation for branch b is F = I0·c(b,0,0) + Q0·c(b,0,1) + I1·c(b,1,0) + Q1·c(b,1,1). The coefficient is c(b,s,p) = ((37b + 19s + 53p + 5) mod 128) − 64, where s is the sample index and p is 0 for the real part and 1 for the imaginary part. Samples are 7-bit two's complement.
- R4: Metric b equals bits [13:5] of (F + 16) in two's complement. This is the same as dropping the top two bits of the 16-bit result and rounding half up to 9 bits, with wraparound. It holds at the extreme inputs −64 and +63.
- R5: `metric_valid` goes high for exactly one clock. It is registered 7 clock edges after the edge that captures sample 1.
- R6: A sample offered while the computation is running is ignored. It changes neither the current metrics nor the pairing of the following samples.
- R7: Between strobes the metric outputs hold their last value.
- R8: Metric b occupies bits [9b+8 : 9b] of `metrics`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample present on `samp_i`/`samp_q` |
| samp_i | input | 7 | In-phase sample, two's complement |
| samp_q | input | 7 | Quadrature sample, two's complement |
| metrics | output | 72 | Eight 9-bit branch metrics, branch 0 in the low bits |
| metric_valid | output | 1 | One-clock strobe when all metrics are new |

## Verification
The bench sweeps sample 0's in-phase value over all 128 codes, with the other three samples following derived patterns. It adds the all-minimum, all-maximum and alternating extremes.

If the sign bit were added instead of subtracted, every metric with a negative sample would be wrong. Rounding by truncation would be off by one on about half the codes. A design that saturated instead of wrapping would disagree at the extremes.

The bench pokes a sample in mid-computation. A design that latched it would corrupt the metrics or shift the pairing of every later symbol. Strobe timing and hold are checked on every symbol, which catches an off-by-one cycle count or outputs that move between strobes.

// File: rtl/cpm_bm_bank.sv
module cpm_bm_bank #(
  parameter int SW   = 7,
  parameter int CW   = 7,
  parameter int NB   = 8,
  parameter int BW   = 9,
  parameter int DROP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_valid,
  input  logic [SW-1:0]    samp_i,
  input  logic [SW-1:0]    samp_q,
  output logic [NB*BW-1:0] metrics,
  output logic             metric_valid
);
  localparam int FW   = SW + CW + 2;
  localparam int KEEP = FW - DROP;
  localparam int SH   = KEEP - BW;
  localparam int CNTW = (SW > 1) ? $clog2(SW) : 1;

  function automatic logic signed [CW-1:0] coef(int b, int s, int p);
    int v;
    v = (b * 37 + s * 19 + p * 53 + 5) % (1 << CW);
    return CW'(v - (1 << (CW - 1)));
  endfunction

  logic [SW-1:0] s0i, s0q, s1i, s1q;
  logic          phase, busy;
  logic [CNTW-1:0] cnt;
  logic signed [FW-1:0] acc    [NB];
  logic signed [FW-1:0] acc_nx [NB];

  wire last = (cnt == CNTW'(SW - 1));
  wire bi0 = s0i[cnt];
  wire bq0 = s0q[cnt];
  wire bi1 = s1i[cnt];
  wire bq1 = s1q[cnt];

  for (genvar b = 0; b < NB; b++) begin : g_br
    localparam logic signed [FW-1:0] XR0 = FW'(coef(b, 0, 0));
    localparam logic signed [FW-1:0] XI0 = FW'(coef(b, 0, 1));
    localparam logic signed [FW-1:0] XR1 = FW'(coef(b, 1, 0));
    localparam logic signed [FW-1:0] XI1 = FW'(coef(b, 1, 1));
    logic signed [FW-1:0] term, shifted;
    assign term = (bi0 ? XR0 : '0) + (bq0 ? XI0 : '0)
                + (bi1 ? XR1 : '0) + (bq1 ? XI1 : '0);
    assign shifted = term <<< cnt;
    assign acc_nx[b] = last ? acc[b] - shifted : acc[b] + shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0i <= '0; s0q <= '0; s1i <= '0; s1q <= '0;
      phase <= 1'b0;
      busy <= 1'b0;
      cnt <= '0;
      metrics <= '0;
      metric_valid <= 1'b0;
      for (int b = 0; b < NB; b++) acc[b] <= '0;
    end else begin
      metric_valid <= 1'b0;
      if (busy) begin
        cnt <= cnt + 1'b1;
        for (int b = 0; b < NB; b++) acc[b] <= acc_nx[b];
        if (last) begin
          busy <= 1'b0;
          metric_valid <= 1'b1;
          for (int b = 0; b < NB; b++)
            metrics[b*BW +: BW] <=
              BW'((acc_nx[b][KEEP-1:0] + KEEP'(1 << (SH - 1))) >> SH);
        end
      end else if (samp_valid) begin
        if (!phase) begin
          s0i <= samp_i;
          s0q <= samp_q;
          phase <= 1'b1;
        end else begin
          s1i <= samp_i;
          s1q <= samp_q;
          phase <= 1'b0;
          busy <= 1'b1;
          cnt <= '0;
          for (int b = 0; b < NB; b++) acc[b] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cpm_bm_bank_chk.sv
module cpm_bm_bank_chk #(
  parameter int MW = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          samp_valid,
  input logic          busy,
  input logic          metric_valid,
  input logic [MW-1:0] metrics
);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |=> !metric_valid);

  a_r5_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> metric_valid);

  a_r5_after_work: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> $past(busy));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !metric_valid |-> $stable(metrics));

  a_r2_start_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(samp_valid));
endmodule

bind cpm_bm_bank cpm_bm_bank_chk #(.MW(NB*BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .busy(busy),
  .metric_valid(metric_valid), .metrics(metrics)
);

// File: tb/cpm_bm_bank_tb_top.sv
`timescale 1ns/1ps
module cpm_bm_bank_tb_top;
  localparam int SW = 7, NB = 8, BW = 9;

  logic clk = 1'b0, rst_n = 1'b0, samp_valid = 1'b0;
  logic [SW-1:0] samp_i = '0, samp_q = '0;
  logic [NB*BW-1:0] metrics;
  logic metric_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  cpm_bm_bank dut_i (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_i(samp_i),
    .samp_q(samp_q), .metrics(metrics), .metric_valid(metric_valid)
  );

  always #5 clk = ~clk;

  function automatic int cf(int b, int s, int p);
    return ((b * 37 + s * 19 + p * 53 + 5) % 128) - 64;
  endfunction

  function automatic int expm(int b, int i0, int q0, int i1, int q1);
    int f;
    f = i0 * cf(b,0,0) + q0 * cf(b,0,1) + i1 * cf(b,1,0) + q1 * cf(b,1,1);
    return ((f + 16) >>> 5) & 511;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_sym(int i0, int q0, int i1, int q1, bit poke, string tag);
    logic [NB*BW-1:0] snap;
    @(negedge clk); samp_valid = 1'b1; samp_i = SW'(i0); samp_q = SW'(q0);
    @(negedge clk); samp_i = SW'(i1); samp_q = SW'(q1);
    @(negedge clk); samp_valid = 1'b0; samp_i = '0; samp_q = '0;
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n < 7) check(metric_valid == 1'b0, "R5 strobe early", int'(metric_valid), 0);
      if (poke && n == 2) begin samp_valid = 1'b1; samp_i = 7'h2a; samp_q = 7'h55; end
      if (n == 3) begin samp_valid = 1'b0; samp_i = '0; samp_q = '0; end
    end
    check(metric_valid == 1'b1, "R5 strobe at edge 7", int'(metric_valid), 1);
    for (int b = 0; b < NB; b++)
      check(int'(metrics[b*BW +: BW]) == expm(b, i0, q0, i1, q1),
            $sformatf("%s R8 branch %0d", tag, b),
            int'(metrics[b*BW +: BW]), expm(b, i0, q0, i1, q1));
    snap = metrics;
    @(negedge clk);
    check(metric_valid == 1'b0, "R5 strobe width", int'(metric_valid), 0);
    check(metrics == snap, "R7 hold after strobe", int'(metrics[BW-1:0]), int'(snap[BW-1:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(metric_valid == 1'b0, "R1 valid in reset", int'(metric_valid), 0);
    check(metrics == '0, "R1 metrics in reset", int'(metrics[BW-1:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(metric_valid == 1'b0, "R1 valid after reset", int'(metric_valid), 0);
    check(metrics == '0, "R1 metrics after reset", int'(metrics[BW-1:0]), 0);

    for (int v = -64; v < 64; v++)
      run_sym(v, -1 - v, (((v + 64) * 5) % 128) - 64, (((v + 64) * 11) % 128) - 64,
              (v % 16) == 0, "R3");

    run_sym(-64, -64, -64, -64, 1'b0, "R4 all min");
    run_sym(63, 63, 63, 63, 1'b0, "R4 all max");
    run_sym(-64, 63, -64, 63, 1'b0, "R4 alternate");
    run_sym(63, -64, 63, -64, 1'b0, "R4 alternate inv");
    run_sym(0, 0, 0, 0, 1'b0, "R4 zero");
    run_sym(1, -1, 0, 0, 1'b0, "R4 small");

    run_sym(17, -30, 5, 44, 1'b1, "R6 poked");
    run_sym(-9, 22, 40, -51, 1'b0, "R6 pairing after poke");
    run_sym(40, -51, -9, 22, 1'b0, "R2 order swapped");
    run_sym(-9, 22, 40, -51, 1'b0, "R2 order restored");

    begin
      logic [NB*BW-1:0] hold;
      hold = metrics;
      repeat (12) @(negedge clk);
      check(metrics == hold, "R7 long idle", int'(metrics[BW-1:0]), int'(hold[BW-1:0]));
      check(metric_valid == 1'b0, "R5 no spurious strobe", int'(metric_valid), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule